// File: doc/BRIEF.md
# Vector-Driven Bus Traffic Generator

This block is a programmable test master for a memory-mapped bus with pipelined reads. Software loads a list of up to 64 vectors through a small control-side register port. Each vector is a read or a write with a 16-bit address and a 32-bit data word. On a go command the block replays the list onto the bus. It issues one command per clock unless the bus stalls it with a wait signal. It can repeat the list a programmed number of times.

A read vector either checks its returning data against the data word, counting any mismatch, or captures the data into a result store indexed by vector position. Up to eight reads may be in flight. The responses come back in order. A cycle counter and a completed-pass counter support performance measurement. An external run input lets another agent start a loaded run or hold it. While that input is low, no new command is issued and reads already in flight still complete. Several generators can be gated together this way.

Top module: `vec_traffic_gen`

## Requirements
- R1: A write vector presents exactly one accepted write (`bus_wr`) carrying its address and data. A read vector presents one accepted read (`bus_rd`) at its address. The two strobes are never high together. Each pass issues vectors 0 to entries-1 in order.
- R2: While a command is presented and `bus_wait` is high, the strobe, address and write data stay unchanged on the next cycle.
- R3: A command is accepted on every clock where `bus_wait` is low and the run is neither held nor out of read slots. The cycle counter counts the clock edges from the go edge up to and including the edge that ends the run. For a write-only list with no stalls this equals entries x passes + 1.
- R4: For a read whose compare bit is set, returned data that differs from the vector's data increments the error counter and sets the sticky error bit. For a read with the compare bit clear, the returned data is written into result slot [vector index].
- R5: A loop count of 0 or 1 gives one pass over the list, and a loop count N > 1 gives N passes. The pass counter increments when the last vector of a pass is accepted. A list of zero entries issues nothing and ends one edge after go.
- R6: At most 8 reads are outstanding. A read is not issued while 8 are outstanding.
- R7: While `ext_run` is low, no new command is presented. A command that was stalled stays presented until accepted, and outstanding reads keep returning.
- R8: The run ends, setting done and dropping busy, only after the final pass has issued its last vector and every outstanding read has returned. The status register holds busy in bit 0, done in bit 1 and sticky error in bit 2. The `busy` port mirrors bit 0.
- R9: Writing control bit 1 (stop) ends issuing without setting done. Control bit 2 (clear) zeroes all counters and status flags. Control bit 0 (go) is ignored while busy, and otherwise starts a run with the counters, done and error zeroed.
- R10: The control word offsets are: 0 control, 1 status, 2 loop count, 3 entry count (writes above 64 store 64), 4 cycles, 5 passes, 6 errors, 7 vector index, 8 vector header ({compare bit 17, read bit 16, address 15:0}), 9 vector data, and 10 result at the vector index. A write to offset 9 stores the header and data at the index and then increments the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_addr | input | 4 | Control register word offset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data for `ctl_addr` (combinational) |
| ext_run | input | 1 | High lets a started run issue commands; low holds it |
| busy | output | 1 | Run in progress |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Returned read data |
| bus_rvalid | input | 1 | Read data valid, in request order |
| bus_wait | input | 1 | Bus stall; the presented command is not accepted |

## Verification
The assertions assume a bus that returns read data strictly in request order and never raises `bus_rvalid` with no read outstanding. They also assume that clear is not written while a command is stalled on the bus. The bench's slave model keeps a response queue that only pops entries pushed on earlier cycles, and it draws its stall and response timing at random. Clear is written only after the stop test has drained the queue.

// File: rtl/vec_traffic_gen.sv
`timescale 1ns/1ps
module vec_traffic_gen #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int OUTS  = 8,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ctl_addr,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic          ext_run,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rvalid,
  input  logic          bus_wait
);
  localparam int IW = $clog2(DEPTH);
  localparam int EW = IW + 1;
  localparam int FW = $clog2(OUTS);
  localparam int CW = FW + 1;
  localparam int VW = AW + DW + 2;

  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_LOOP = 4'd2, A_ENTR = 4'd3,
                         A_CYC  = 4'd4, A_PASS = 4'd5, A_ERR  = 4'd6, A_VIDX = 4'd7,
                         A_HDR  = 4'd8, A_VDAT = 4'd9, A_RES  = 4'd10;

  logic [VW-1:0] vmem [DEPTH];
  logic [DW-1:0] rmem [DEPTH];
  logic [DW-1:0] f_exp [OUTS];
  logic          f_cmp [OUTS];
  logic [IW-1:0] f_idx [OUTS];

  logic          armed, done_f, err_f, hold, issued_all;
  logic [IW-1:0] ptr, vidx;
  logic [EW-1:0] entries;
  logic [LW-1:0] loops, pass_n;
  logic [31:0]   cyc, passes, errs;
  logic [AW+1:0] hdr;
  logic [FW-1:0] wp, rp;
  logic [CW-1:0] fcnt;

  wire [VW-1:0] cur     = vmem[ptr];
  wire          cur_rd  = cur[VW-1];
  wire          cur_cmp = cur[VW-2];
  wire          f_full  = (fcnt == CW'(OUTS));
  wire          present = hold | (armed & ext_run & ~issued_all & ~(cur_rd & f_full));
  wire          accept  = present & ~bus_wait;
  wire          push    = accept & cur_rd;
  wire          pop     = bus_rvalid & (fcnt != '0);
  wire          miss    = pop & f_cmp[rp] & (bus_rdata != f_exp[rp]);
  wire [LW-1:0] tot     = (loops == '0) ? LW'(1) : loops;
  wire          lastv   = ((EW'(ptr) + EW'(1)) == entries);
  wire          lastp   = ((pass_n + LW'(1)) == tot);
  wire          finish  = armed & issued_all & (fcnt == '0) & ~hold;

  wire wr_ctrl = ctl_wr & (ctl_addr == A_CTRL);
  wire go      = wr_ctrl & ctl_wdata[0] & ~armed;
  wire stop    = wr_ctrl & ctl_wdata[1];
  wire clr     = wr_ctrl & ctl_wdata[2];

  assign busy      = armed;
  assign bus_rd    = present & cur_rd;
  assign bus_wr    = present & ~cur_rd;
  assign bus_addr  = cur[AW+DW-1:DW];
  assign bus_wdata = cur[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      armed <= 1'b0; done_f <= 1'b0; err_f <= 1'b0; hold <= 1'b0; issued_all <= 1'b0;
      ptr <= '0; pass_n <= '0; cyc <= '0; passes <= '0; errs <= '0;
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      hold <= present & bus_wait;
      if (armed) cyc <= cyc + 32'd1;
      if (accept) begin
        if (lastv) begin
          ptr    <= '0;
          passes <= passes + 32'd1;
          if (lastp) issued_all <= 1'b1;
          else       pass_n     <= pass_n + LW'(1);
        end else begin
          ptr <= ptr + IW'(1);
        end
      end
      if (push) wp <= wp + FW'(1);
      if (pop)  rp <= rp + FW'(1);
      fcnt <= fcnt + CW'(push) - CW'(pop);
      if (miss) begin
        errs  <= errs + 32'd1;
        err_f <= 1'b1;
      end
      if (stop) armed <= 1'b0;
      else if (finish) begin
        armed  <= 1'b0;
        done_f <= 1'b1;
      end
      if (go) begin
        armed <= 1'b1; ptr <= '0; pass_n <= '0; issued_all <= (entries == '0);
        done_f <= 1'b0; err_f <= 1'b0; cyc <= '0; passes <= '0; errs <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_exp[wp] <= cur[DW-1:0];
      f_cmp[wp] <= cur_cmp;
      f_idx[wp] <= ptr;
    end
    if (pop && !f_cmp[rp]) rmem[f_idx[rp]] <= bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loops <= '0; entries <= '0; vidx <= '0; hdr <= '0;
    end else if (ctl_wr) begin
      case (ctl_addr)
        A_LOOP: loops <= ctl_wdata[LW-1:0];
        A_ENTR: entries <= (ctl_wdata > 32'(DEPTH)) ? EW'(DEPTH) : ctl_wdata[EW-1:0];
        A_VIDX: vidx <= ctl_wdata[IW-1:0];
        A_HDR:  hdr <= ctl_wdata[AW+1:0];
        A_VDAT: vidx <= vidx + IW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (ctl_wr && ctl_addr == A_VDAT)
      vmem[vidx] <= {hdr[AW], hdr[AW+1], hdr[AW-1:0], ctl_wdata[DW-1:0]};

  always_comb begin
    ctl_rdata = '0;
    case (ctl_addr)
      A_STAT: ctl_rdata = {29'd0, err_f, done_f, armed};
      A_LOOP: ctl_rdata = 32'(loops);
      A_ENTR: ctl_rdata = 32'(entries);
      A_CYC:  ctl_rdata = cyc;
      A_PASS: ctl_rdata = passes;
      A_ERR:  ctl_rdata = errs;
      A_VIDX: ctl_rdata = 32'(vidx);
      A_HDR:  ctl_rdata = 32'(hdr);
      A_RES:  ctl_rdata = 32'(rmem[vidx]);
      default: ctl_rdata = '0;
    endcase
  end
endmodule

module vec_traffic_gen_chk #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int OUTS = 8,
  parameter int CW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_wait,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          ext_run,
  input logic          busy,
  input logic          done_f,
  input logic [CW-1:0] fcnt
);
  AST_SINGLE_CMD: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R1
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && bus_wait |=> bus_rd == $past(bus_rd) && bus_wr == $past(bus_wr)
      && $stable(bus_addr) && $stable(bus_wdata)); // R2
  AST_OUTS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) fcnt <= CW'(OUTS)); // R6
  AST_NO_READ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wait |-> fcnt < CW'(OUTS)); // R6
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_run && !$past((bus_rd || bus_wr) && bus_wait) |-> !(bus_rd || bus_wr)); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> fcnt == '0 && !busy); // R8
endmodule

bind vec_traffic_gen vec_traffic_gen_chk #(.AW(AW), .DW(DW), .OUTS(OUTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wait(bus_wait),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ext_run(ext_run), .busy(busy),
  .done_f(done_f), .fcnt(fcnt)
);

// File: tb/sim_vec_traffic_gen.sv
`timescale 1ns/1ps
module sim_vec_traffic_gen;
  logic clk = 0, rst_n = 0;
  logic [3:0] ctl_addr = 0;
  logic ctl_wr = 0;
  logic [31:0] ctl_wdata = 0, ctl_rdata;
  logic ext_run = 1, busy;
  logic [15:0] bus_addr;
  logic bus_rd, bus_wr, bus_rvalid = 0, bus_wait = 0;
  logic [31:0] bus_wdata, bus_rdata = 0;

  always #2 clk = ~clk;

  vec_traffic_gen u0 (.clk(clk), .rst_n(rst_n), .ctl_addr(ctl_addr), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ext_run(ext_run), .busy(busy),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_wait(bus_wait));

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];
  logic [31:0] smem [256];
  logic [31:0] q [16];
  logic [3:0] qh = 0, qt = 0;
  int qn = 0, wait_pct = 0, rsp_pct = 100;
  int acc_cnt = 0, max_out = 0, busy_cyc = 0, r2_bad = 0, r7_bad = 0;
  logic prev_stall = 0, prev_rd = 0;
  logic [15:0] prev_addr = 0;
  logic [31:0] prev_wd = 0;
  logic tv_rd [64], tv_cmp [64], res_ok [64];
  logic [15:0] tv_a [64];
  logic [31:0] tv_d [64], exp_res [64];
  int exp_err;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (qn > 0 && ($urandom % 100) < rsp_pct) begin
        bus_rvalid = 1; bus_rdata = q[qh]; qh = qh + 1; qn--;
      end else begin
        bus_rvalid = 0; bus_rdata = $urandom;
      end
      if (prev_stall && (!(bus_rd || bus_wr) || bus_rd != prev_rd || bus_addr != prev_addr
          || (!bus_rd && bus_wdata != prev_wd))) r2_bad++;
      if (!ext_run && !prev_stall && (bus_rd || bus_wr)) r7_bad++;
      bus_wait = ($urandom % 100) < wait_pct;
      if (bus_rd && !bus_wait) begin
        q[qt] = mem[bus_addr[7:0]]; qt = qt + 1; qn++; acc_cnt++;
      end
      if (bus_wr && !bus_wait) begin
        mem[bus_addr[7:0]] = bus_wdata; acc_cnt++;
      end
      if (qn > max_out) max_out = qn;
      if (busy) busy_cyc++;
      prev_stall = (bus_rd || bus_wr) && bus_wait;
      prev_rd = bus_rd; prev_addr = bus_addr; prev_wd = bus_wdata;
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); ctl_addr = a; ctl_wdata = d; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); ctl_addr = a; #1; v = ctl_rdata;
  endtask

  task automatic gen_load(input int n, input int mode);
    logic [31:0] g [256];
    for (int k = 0; k < 256; k++) g[k] = mem[k];
    for (int i = 0; i < n; i++) begin
      tv_rd[i] = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom % 2);
      tv_a[i] = 16'($urandom % 32) | ($urandom % 2 == 0 ? 16'h0 : 16'hA500);
      tv_cmp[i] = tv_rd[i] && ($urandom % 3 != 0);
      if (!tv_rd[i]) begin
        tv_d[i] = $urandom; g[tv_a[i][7:0]] = tv_d[i];
      end else begin
        tv_d[i] = g[tv_a[i][7:0]] ^ (($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0);
      end
    end
    wr_reg(7, 0);
    for (int i = 0; i < n; i++) begin
      wr_reg(8, {14'd0, tv_cmp[i], tv_rd[i], tv_a[i]});
      wr_reg(9, tv_d[i]);
    end
  endtask

  task automatic model(input int n, input int total);
    exp_err = 0;
    for (int k = 0; k < 256; k++) smem[k] = mem[k];
    for (int i = 0; i < 64; i++) res_ok[i] = 0;
    for (int p = 0; p < total; p++)
      for (int i = 0; i < n; i++) begin
        if (!tv_rd[i]) smem[tv_a[i][7:0]] = tv_d[i];
        else if (tv_cmp[i]) begin
          if (smem[tv_a[i][7:0]] != tv_d[i]) exp_err++;
        end else begin
          exp_res[i] = smem[tv_a[i][7:0]]; res_ok[i] = 1;
        end
      end
  endtask

  task automatic run_case(input int n, input int loops, input int wp, input int rp,
                          input bit pause, input int mode);
    int total, guard, bad;
    logic [31:0] v;
    total = (loops == 0) ? 1 : loops;
    gen_load(n, mode);
    wr_reg(3, n); wr_reg(2, loops);
    model(n, total);
    wait_pct = wp; rsp_pct = rp;
    acc_cnt = 0; max_out = 0; busy_cyc = 0; r2_bad = 0; r7_bad = 0;
    wr_reg(0, 1);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      if (pause) ext_run = ($urandom % 3 != 0);
      guard++;
    end
    ext_run = 1;
    chk(guard < 20000, "R8 run ended", guard, 0);
    rd_reg(1, v); chk(v[2:0] == {exp_err != 0, 2'b10}, "R8 R4 status", v[2:0], {exp_err != 0, 2'b10});
    rd_reg(6, v); chk(v == exp_err, "R4 error count", v, exp_err);
    rd_reg(5, v); chk(v == ((n == 0) ? 0 : total), "R5 passes", v, (n == 0) ? 0 : total);
    rd_reg(4, v); chk(v == busy_cyc, "R3 cycle count", v, busy_cyc);
    if (wp == 0 && rp == 100 && !pause && mode == 1)
      chk(v == n * total + 1, "R3 back to back", v, n * total + 1);
    chk(acc_cnt == n * total, "R1 accepted commands", acc_cnt, n * total);
    bad = 0;
    for (int k = 0; k < 256; k++) if (mem[k] != smem[k]) bad++;
    chk(bad == 0, "R1 memory image", bad, 0);
    bad = 0;
    for (int i = 0; i < n; i++) if (res_ok[i]) begin
      wr_reg(7, i); rd_reg(10, v);
      if (v != exp_res[i]) bad++;
    end
    chk(bad == 0, "R4 result store", bad, 0);
    chk(max_out <= 8, "R6 outstanding limit", max_out, 8);
    chk(r2_bad == 0, "R2 held command", r2_bad, 0);
    chk(r7_bad == 0, "R7 pause quiet", r7_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int k = 0; k < 256; k++) mem[k] = $urandom;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd_reg(1, v); chk(v == 0, "R8 reset status", v, 0);
    rd_reg(4, v); chk(v == 0, "R3 reset cycles", v, 0);
    chk(!(bus_rd || bus_wr), "R1 reset idle bus", bus_rd | bus_wr, 0);

    run_case(12, 3, 0, 100, 0, 1);
    run_case(0, 0, 0, 100, 0, 1);
    run_case(20, 0, 30, 60, 0, 0);
    run_case(30, 4, 20, 50, 1, 0);
    run_case(40, 2, 0, 5, 0, 2);
    chk(max_out == 8, "R6 slots filled", max_out, 8);
    run_case(64, 1, 10, 70, 0, 0);
    for (int r = 0; r < 3; r++)
      run_case(1 + $urandom % 64, $urandom % 4, $urandom % 50, 20 + $urandom % 80, r[0], 0);

    gen_load(40, 2);
    wr_reg(3, 40); wr_reg(2, 5);
    wait_pct = 0; rsp_pct = 10; acc_cnt = 0;
    wr_reg(0, 1);
    repeat (15) @(negedge clk);
    wr_reg(0, 2);
    for (int g = 0; g < 2000 && qn > 0; g++) @(negedge clk);
    repeat (3) @(negedge clk);
    rd_reg(1, v); chk(v[1:0] == 0, "R9 stop not done", v[1:0], 0);
    chk(!(bus_rd || bus_wr), "R9 stop quiet", bus_rd | bus_wr, 0);
    chk(acc_cnt < 200, "R9 stop cut run", acc_cnt, 200);
    wr_reg(0, 4);
    rd_reg(4, v); chk(v == 0, "R9 clear cycles", v, 0);
    rd_reg(5, v); chk(v == 0, "R9 clear passes", v, 0);
    rd_reg(6, v); chk(v == 0, "R9 clear errors", v, 0);
    rd_reg(1, v); chk(v == 0, "R9 clear status", v, 0);

    wr_reg(3, 100); rd_reg(3, v); chk(v == 64, "R10 entry clamp", v, 64);
    wr_reg(7, 5); wr_reg(8, 32'h3_1234); wr_reg(9, 32'hCAFE);
    rd_reg(7, v); chk(v == 6, "R10 index advance", v, 6);
    rd_reg(8, v); chk(v == 32'h3_1234, "R10 header readback", v, 32'h3_1234);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule